// File: doc/BRIEF.md
# Front-End Fast Command Decoder

This block sits at the front end and takes in one 24-bit timing word on every bunch-crossing clock cycle. Each word carries a 12-bit bunch identifier and a group of command flags. Every command in a word applies to the crossing named by that word's identifier. Words leave the central controller well ahead of the crossing they describe, and the link cannot delay individual lines. For that reason each command runs through its own delay line, with a delay the local logic can set. This moves each command back onto the crossing it was meant for.

The block also keeps a local bunch counter that runs freely and wraps once per orbit. The orbit reset command re-aligns the counter. The received identifier is checked against the counter, and a sticky flag reports any disagreement. The front-end reset strobe is passed out for the processing logic and never touches the counter. The snapshot strobe freezes a copy of the counter and the flag, so that all monitoring values are taken at the same instant.

Top module: `fe_tfc_decoder`

## Requirements
- R1: Word layout: bits [11:0] identifier, bit 12 orbit (counter) reset, bit 13 front-end reset, bit 14 header-only, bit 15 crossing veto, bits [19:16] calibration type, bit 20 non-zero-suppressed readout, bit 21 snapshot. The word is sampled on every clock edge.
- R2: Channel i has its delay at `dly_cfg_i[5*i +: 5]`. Channels are 0 orbit reset (which carries the identifier with it), 1 front-end reset, 2 header-only, 3 veto, 4 calibration, 5 non-zero-suppressed and 6 snapshot. With a setting d from 0 to 31, a flag in the word sampled at edge E is driven on its output after edge E+d, for exactly one cycle.
- R3: Channel delays are independent. Two flags in the same word with different settings each come out at their own delay.
- R4: The 4-bit calibration field is delayed as one group and keeps its value. It reads zero when no calibration command is pending.
- R5: `bcnt_o` goes up by one on every cycle, stays below 3564, and wraps from 3563 to 0.
- R6: A delayed orbit reset forces `bcnt_o` to 0 at the next edge. From then on the counter counts as synchronised.
- R7: The front-end reset strobe leaves the bunch counter unchanged.
- R8: Once the counter is synchronised, a delayed identifier that differs from `bcnt_o` sets `mism_o` at the next edge, and the flag holds. Before the first orbit reset the flag is never set.
- R9: A high `mism_clr_i` at an edge clears `mism_o` if no new disagreement arrives at that edge.
- R10: A delayed snapshot strobe copies `bcnt_o` and `mism_o` into `snap_bcnt_o` and `snap_mism_o` at the next edge.
- R11: Word bits [23:22] have no effect on any output.
- R12: While reset is asserted, every output is zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bunch-crossing clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tfc_word_i | input | 24 | Timing word, one per cycle |
| dly_cfg_i | input | 35 | Seven 5-bit delay settings |
| mism_clr_i | input | 1 | Clears the mismatch flag |
| bcnt_rst_o | output | 1 | Delayed orbit reset strobe |
| fe_rst_o | output | 1 | Delayed front-end reset strobe |
| hdr_only_o | output | 1 | Delayed header-only strobe |
| bx_veto_o | output | 1 | Delayed crossing veto |
| calib_o | output | 4 | Delayed calibration type |
| nzs_o | output | 1 | Delayed non-zero-suppressed request |
| snapshot_o | output | 1 | Delayed snapshot strobe |
| bcnt_o | output | 12 | Local bunch counter |
| mism_o | output | 1 | Sticky identifier mismatch flag |
| snap_bcnt_o | output | 12 | Counter value frozen by snapshot |
| snap_mism_o | output | 1 | Mismatch flag frozen by snapshot |

## Verification
The hardest state to reach is a counter that is synchronised and agrees with the identifier stream. Only then does a single bad identifier set the flag, and only then does the counter wrap with no false alarm. The bench gets there by sending an orbit reset in a word whose identifier is 3563, and by numbering every later word so that it follows on from that one. The counter and the delayed identifiers then agree cycle for cycle. With the stream aligned, the bench walks a full orbit to the wrap. It then sends a front-end reset, one corrupted identifier, a snapshot and a clear, and predicts every counter value from the step at which the count returned to zero.

// File: rtl/fe_tfc_pkg.sv
`timescale 1ns/1ps
package fe_tfc_pkg;
    localparam int WORD_W  = 24;
    localparam int BXID_W  = 12;
    localparam int CAL_W   = 4;
    localparam int NUM_CH  = 7;

    // bit positions in the incoming word
    localparam int POS_BCRST = 12;
    localparam int POS_FERST = 13;
    localparam int POS_HDR   = 14;
    localparam int POS_VETO  = 15;
    localparam int POS_CAL   = 16;
    localparam int POS_NZS   = 20;
    localparam int POS_SNAP  = 21;

    // delay channel indices
    localparam int CH_BCRST = 0;
    localparam int CH_FERST = 1;
    localparam int CH_HDR   = 2;
    localparam int CH_VETO  = 3;
    localparam int CH_CAL   = 4;
    localparam int CH_NZS   = 5;
    localparam int CH_SNAP  = 6;

    // channel 0 carries strobe, identifier and a filled flag
    function automatic int ch_width(input int idx);
        case (idx)
            CH_BCRST: return BXID_W + 2;
            CH_CAL:   return CAL_W;
            default:  return 1;
        endcase
    endfunction

    function automatic int ch_lo(input int idx);
        int acc;
        acc = 0;
        for (int k = 0; k < idx; k++) acc += ch_width(k);
        return acc;
    endfunction

    localparam int CH_BUS_W = ch_lo(NUM_CH);

    typedef struct packed {
        logic              vld;
        logic [BXID_W-1:0] bxid;
        logic              bcrst;
        logic              ferst;
        logic              hdr;
        logic              veto;
        logic [CAL_W-1:0]  cal;
        logic              nzs;
        logic              snap;
    } tfc_fields_t;
endpackage

// File: rtl/tfc_word_split.sv
`timescale 1ns/1ps
module tfc_word_split
    import fe_tfc_pkg::*;
(
    input  logic                clk_i,
    input  logic                rst_ni,
    input  logic [WORD_W-1:0]   word_i,
    output logic [CH_BUS_W-1:0] ch_bus_o
);
    typedef struct packed {
        tfc_fields_t f;
    } split_st_t;

    split_st_t st_d, st_q;
    logic      unused_rsv;

    assign unused_rsv = ^word_i[WORD_W-1:POS_SNAP+1];

    always_comb begin
        st_d         = st_q;
        st_d.f.vld   = 1'b1;
        st_d.f.bxid  = word_i[BXID_W-1:0];
        st_d.f.bcrst = word_i[POS_BCRST];
        st_d.f.ferst = word_i[POS_FERST];
        st_d.f.hdr   = word_i[POS_HDR];
        st_d.f.veto  = word_i[POS_VETO];
        st_d.f.cal   = word_i[POS_CAL +: CAL_W];
        st_d.f.nzs   = word_i[POS_NZS];
        st_d.f.snap  = word_i[POS_SNAP];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    always_comb begin
        ch_bus_o = '0;
        ch_bus_o[ch_lo(CH_BCRST) +: ch_width(CH_BCRST)] = {st_q.f.vld, st_q.f.bxid, st_q.f.bcrst};
        ch_bus_o[ch_lo(CH_FERST)]                      = st_q.f.ferst;
        ch_bus_o[ch_lo(CH_HDR)]                        = st_q.f.hdr;
        ch_bus_o[ch_lo(CH_VETO)]                       = st_q.f.veto;
        ch_bus_o[ch_lo(CH_CAL) +: CAL_W]               = st_q.f.cal;
        ch_bus_o[ch_lo(CH_NZS)]                        = st_q.f.nzs;
        ch_bus_o[ch_lo(CH_SNAP)]                       = st_q.f.snap;
    end
endmodule

// File: rtl/tfc_delay_line.sv
`timescale 1ns/1ps
module tfc_delay_line #(
    parameter int W         = 1,
    parameter int MAX_DELAY = 31,
    parameter int SEL_W     = $clog2(MAX_DELAY + 1)
) (
    input  logic             clk_i,
    input  logic             rst_ni,
    input  logic [SEL_W-1:0] sel_i,
    input  logic [W-1:0]     din_i,
    output logic [W-1:0]     dout_o
);
    typedef struct packed {
        logic [MAX_DELAY-1:0][W-1:0] sr;
    } dl_st_t;

    dl_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        st_d.sr[0] = din_i;
        for (int k = 1; k < MAX_DELAY; k++) st_d.sr[k] = st_q.sr[k-1];
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    // tap select: setting 0 passes the captured value, d picks stage d-1
    always_comb begin
        int tap;
        tap = int'(sel_i);
        if (tap > MAX_DELAY) tap = MAX_DELAY;
        if (tap == 0) dout_o = din_i;
        else          dout_o = st_q.sr[tap-1];
    end
endmodule

// File: rtl/tfc_bunch_track.sv
`timescale 1ns/1ps
module tfc_bunch_track
    import fe_tfc_pkg::*;
#(
    parameter int ORBIT_LEN = 3564
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              bcrst_i,
    input  logic              vld_i,
    input  logic [BXID_W-1:0] bxid_i,
    input  logic              snap_i,
    input  logic              clr_i,
    output logic [BXID_W-1:0] bcnt_o,
    output logic              mism_o,
    output logic [BXID_W-1:0] snap_bcnt_o,
    output logic              snap_mism_o
);
    localparam logic [BXID_W-1:0] LAST = BXID_W'(ORBIT_LEN - 1);

    typedef struct packed {
        logic [BXID_W-1:0] cnt;
        logic              synced;
        logic              mism;
        logic [BXID_W-1:0] snap_cnt;
        logic              snap_mism;
    } trk_st_t;

    trk_st_t st_d, st_q;
    logic    bad;

    always_comb begin
        st_d = st_q;
        // counter: orbit reset wins, otherwise wrap at the orbit end
        if (bcrst_i)            st_d.cnt = '0;
        else if (st_q.cnt == LAST) st_d.cnt = '0;
        else                    st_d.cnt = st_q.cnt + 1'b1;

        st_d.synced = st_q.synced | bcrst_i;

        bad = st_q.synced & vld_i & (bxid_i != st_q.cnt);
        if (bad)        st_d.mism = 1'b1;
        else if (clr_i) st_d.mism = 1'b0;

        if (snap_i) begin
            st_d.snap_cnt  = st_q.cnt;
            st_d.snap_mism = st_q.mism;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign bcnt_o      = st_q.cnt;
    assign mism_o      = st_q.mism;
    assign snap_bcnt_o = st_q.snap_cnt;
    assign snap_mism_o = st_q.snap_mism;
endmodule

// File: rtl/fe_tfc_decoder.sv
`timescale 1ns/1ps
module fe_tfc_decoder
    import fe_tfc_pkg::*;
#(
    parameter int ORBIT_LEN = 3564,
    parameter int MAX_DELAY = 31,
    parameter int SEL_W     = $clog2(MAX_DELAY + 1)
) (
    input  logic                    clk_i,
    input  logic                    rst_ni,
    input  logic [WORD_W-1:0]       tfc_word_i,
    input  logic [NUM_CH*SEL_W-1:0] dly_cfg_i,
    input  logic                    mism_clr_i,
    output logic                    bcnt_rst_o,
    output logic                    fe_rst_o,
    output logic                    hdr_only_o,
    output logic                    bx_veto_o,
    output logic [CAL_W-1:0]        calib_o,
    output logic                    nzs_o,
    output logic                    snapshot_o,
    output logic [BXID_W-1:0]       bcnt_o,
    output logic                    mism_o,
    output logic [BXID_W-1:0]       snap_bcnt_o,
    output logic                    snap_mism_o
);
    logic [CH_BUS_W-1:0] cap_bus;
    logic [CH_BUS_W-1:0] dly_bus;
    logic [BXID_W-1:0]   dly_bxid;
    logic                dly_vld;

    tfc_word_split u_split (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .word_i  (tfc_word_i),
        .ch_bus_o(cap_bus)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        tfc_delay_line #(
            .W        (ch_width(g)),
            .MAX_DELAY(MAX_DELAY),
            .SEL_W    (SEL_W)
        ) u_dl (
            .clk_i (clk_i),
            .rst_ni(rst_ni),
            .sel_i (dly_cfg_i[g*SEL_W +: SEL_W]),
            .din_i (cap_bus[ch_lo(g) +: ch_width(g)]),
            .dout_o(dly_bus[ch_lo(g) +: ch_width(g)])
        );
    end

    assign bcnt_rst_o = dly_bus[ch_lo(CH_BCRST)];
    assign dly_bxid   = dly_bus[ch_lo(CH_BCRST) + 1 +: BXID_W];
    assign dly_vld    = dly_bus[ch_lo(CH_BCRST) + 1 + BXID_W];
    assign fe_rst_o   = dly_bus[ch_lo(CH_FERST)];
    assign hdr_only_o = dly_bus[ch_lo(CH_HDR)];
    assign bx_veto_o  = dly_bus[ch_lo(CH_VETO)];
    assign calib_o    = dly_bus[ch_lo(CH_CAL) +: CAL_W];
    assign nzs_o      = dly_bus[ch_lo(CH_NZS)];
    assign snapshot_o = dly_bus[ch_lo(CH_SNAP)];

    tfc_bunch_track #(.ORBIT_LEN(ORBIT_LEN)) u_trk (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .bcrst_i    (bcnt_rst_o),
        .vld_i      (dly_vld),
        .bxid_i     (dly_bxid),
        .snap_i     (snapshot_o),
        .clr_i      (mism_clr_i),
        .bcnt_o     (bcnt_o),
        .mism_o     (mism_o),
        .snap_bcnt_o(snap_bcnt_o),
        .snap_mism_o(snap_mism_o)
    );
endmodule

// File: rtl/fe_tfc_decoder_chk.sv
`timescale 1ns/1ps
module fe_tfc_decoder_chk #(
    parameter int ORBIT_LEN = 3564
) (
    input logic        clk_i,
    input logic        rst_ni,
    input logic        mism_clr_i,
    input logic        bcnt_rst_o,
    input logic        fe_rst_o,
    input logic        snapshot_o,
    input logic [11:0] bcnt_o,
    input logic        mism_o,
    input logic [11:0] snap_bcnt_o
);
    localparam logic [11:0] LAST = 12'(ORBIT_LEN - 1);

    p_bcnt_range_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        bcnt_o <= LAST);

    p_bcnt_wrap_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bcnt_o == LAST && !bcnt_rst_o) |=> bcnt_o == 12'd0);

    p_bcnt_load_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
        bcnt_rst_o |=> bcnt_o == 12'd0);

    p_ferst_keep_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (fe_rst_o && !bcnt_rst_o && bcnt_o != LAST) |=> bcnt_o == $past(bcnt_o) + 12'd1);

    p_mism_sticky_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (mism_o && !mism_clr_i) |=> mism_o);

    p_snap_latch_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
        snapshot_o |=> snap_bcnt_o == $past(bcnt_o));
endmodule

bind fe_tfc_decoder fe_tfc_decoder_chk #(.ORBIT_LEN(ORBIT_LEN)) u_chk (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .mism_clr_i (mism_clr_i),
    .bcnt_rst_o (bcnt_rst_o),
    .fe_rst_o   (fe_rst_o),
    .snapshot_o (snapshot_o),
    .bcnt_o     (bcnt_o),
    .mism_o     (mism_o),
    .snap_bcnt_o(snap_bcnt_o)
);

// File: tb/fe_tfc_decoder_tb.sv
`timescale 1ns/1ps
module fe_tfc_decoder_tb;
    localparam int ORB = 3564;
    localparam logic [23:0] B_BCRST = 24'h001000;
    localparam logic [23:0] B_FERST = 24'h002000;
    localparam logic [23:0] B_HDR   = 24'h004000;
    localparam logic [23:0] B_VETO  = 24'h008000;
    localparam logic [23:0] B_NZS   = 24'h100000;
    localparam logic [23:0] B_SNAP  = 24'h200000;
    localparam logic [23:0] B_RSV   = 24'hC00000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [23:0] word = '0;
    logic [34:0] cfg = '0;
    logic        clr = 1'b0;
    logic        bcnt_rst, fe_rst, hdr, veto, nzs, snap, mism, snap_mism;
    logic [3:0]  cal;
    logic [11:0] bcnt, snap_bcnt;

    // sampled copies
    logic        s_bcrst, s_ferst, s_hdr, s_veto, s_nzs, s_snap, s_mism, s_smism;
    logic [3:0]  s_cal;
    logic [11:0] s_bcnt, s_sbcnt;

    int n_chk = 0, n_fail = 0;
    int stp = 0, s0 = 0, cur_id = 0;
    bit finished = 0;

    always #4 clk = ~clk;

    fe_tfc_decoder u_dut (
        .clk_i(clk), .rst_ni(rst_n), .tfc_word_i(word), .dly_cfg_i(cfg),
        .mism_clr_i(clr), .bcnt_rst_o(bcnt_rst), .fe_rst_o(fe_rst),
        .hdr_only_o(hdr), .bx_veto_o(veto), .calib_o(cal), .nzs_o(nzs),
        .snapshot_o(snap), .bcnt_o(bcnt), .mism_o(mism),
        .snap_bcnt_o(snap_bcnt), .snap_mism_o(snap_mism)
    );

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic sample();
        s_bcrst = bcnt_rst; s_ferst = fe_rst; s_hdr = hdr; s_veto = veto;
        s_nzs = nzs; s_snap = snap; s_mism = mism; s_smism = snap_mism;
        s_cal = cal; s_bcnt = bcnt; s_sbcnt = snap_bcnt;
    endtask

    // one cycle: sample state left by the last edge, then drive the next word
    task automatic step(input logic [23:0] cmd, input bit bad_id = 0);
        @(negedge clk);
        stp++;
        sample();
        word = cmd | 24'(bad_id ? ((cur_id + 7) % ORB) : cur_id);
        cur_id = (cur_id + 1) % ORB;
    endtask

    task automatic set_dly(input int ch, input int d);
        cfg[ch*5 +: 5] = 5'(d);
    endtask

    task automatic flush();
        for (int i = 0; i < 34; i++) step('0);
    endtask

    function automatic int exp_cnt(input int s);
        return (s - s0) % ORB;
    endfunction

    function automatic bit pick(input int sel);
        case (sel)
            0: return s_bcrst;
            1: return s_ferst;
            2: return s_hdr;
            3: return s_veto;
            5: return s_nzs;
            default: return s_snap;
        endcase
    endfunction

    task automatic t_reset();
        repeat (3) @(negedge clk);
        sample();
        chk({s_bcrst, s_ferst, s_hdr, s_veto, s_nzs, s_snap, s_mism, s_smism} == '0 && s_cal == 0,
            "R12", "strobes and flags in reset", 0, 0);
        chk(s_bcnt == 0 && s_sbcnt == 0, "R12", "counters in reset", int'(s_bcnt), 0);
        rst_n = 1'b1;
    endtask

    // R2: single flag leaves after exactly d+1 steps, once
    task automatic t_pulse(input logic [23:0] cmd, input int sel, input int d, input string req);
        int first, cnt;
        set_dly(sel, d);
        flush();
        step(cmd);
        first = -1; cnt = 0;
        for (int i = 1; i <= 40; i++) begin
            step('0);
            if (pick(sel)) begin
                cnt++;
                if (first < 0) first = i;
            end
        end
        chk(first == d + 1 && cnt == 1, req, $sformatf("channel %0d pulse step (count %0d)", sel, cnt), first, d + 1);
    endtask

    task automatic t_calib(input logic [3:0] v, input int d);
        int bad;
        set_dly(4, d);
        flush();
        step(24'(v) << 16);
        bad = 0;
        for (int i = 1; i <= 40; i++) begin
            step('0);
            if (s_cal != ((i == d + 1) ? v : 4'd0)) bad++;
        end
        chk(bad == 0, "R4", $sformatf("calibration %0h delay %0d wrong steps", v, d), bad, 0);
    endtask

    task automatic t_indep();
        int fh, fn;
        set_dly(2, 2); set_dly(5, 20);
        flush();
        step(B_HDR | B_NZS);
        fh = -1; fn = -1;
        for (int i = 1; i <= 30; i++) begin
            step('0);
            if (s_hdr && fh < 0) fh = i;
            if (s_nzs && fn < 0) fn = i;
        end
        chk(fh == 3, "R3", "header-only step", fh, 3);
        chk(fn == 21, "R3", "nzs step", fn, 21);
    endtask

    task automatic t_reserved();
        int hits;
        for (int c = 0; c < 7; c++) set_dly(c, 0);
        flush();
        hits = 0;
        step(B_RSV);
        for (int i = 1; i <= 6; i++) begin
            step('0);
            if (s_bcrst | s_ferst | s_hdr | s_veto | s_nzs | s_snap | (|s_cal)) hits++;
        end
        chk(hits == 0, "R11", "outputs touched by reserved bits", hits, 0);
    endtask

    task automatic t_presync();
        for (int i = 0; i < 20; i++) step('0, 1);
        for (int i = 0; i < 5; i++) step('0);
        chk(s_mism == 0, "R8", "flag before synchronisation", s_mism, 0);
    endtask

    task automatic t_sync();
        int k;
        set_dly(0, 3);
        flush();
        cur_id = ORB - 1;
        step(B_BCRST);
        k = stp;
        while (stp < k + 4) step('0);
        chk(s_bcrst == 1, "R6", "orbit reset strobe at delay", s_bcrst, 1);
        step('0);
        chk(s_bcnt == 0, "R6", "counter after orbit reset", int'(s_bcnt), 0);
        s0 = stp;
        repeat (5) step('0);
        chk(s_bcnt == 5, "R5", "counter five cycles later", int'(s_bcnt), 5);
    endtask

    task automatic t_wrap();
        while (exp_cnt(stp) != ORB - 1) step('0);
        chk(s_bcnt == 12'(ORB - 1), "R5", "counter at orbit end", int'(s_bcnt), ORB - 1);
        step('0);
        chk(s_bcnt == 0, "R5", "counter after wrap", int'(s_bcnt), 0);
        chk(s_mism == 0, "R8", "flag with aligned identifiers", s_mism, 0);
    endtask

    task automatic t_ferst();
        int k, drift, fp;
        set_dly(1, 5);
        flush();
        step(B_FERST);
        k = stp; drift = 0; fp = -1;
        for (int i = 1; i <= 12; i++) begin
            step('0);
            if (s_ferst && fp < 0) fp = i;
            if (int'(s_bcnt) != exp_cnt(stp)) drift++;
        end
        chk(fp == 6, "R7", "front-end reset strobe step", fp, 6);
        chk(drift == 0 && s_mism == 0, "R7", "counter disturbed by front-end reset", drift, 0);
    endtask

    task automatic t_mism();
        int k;
        step('0, 1);
        repeat (10) step('0);
        chk(s_mism == 1, "R8", "flag after bad identifier", s_mism, 1);
        repeat (5) step('0);
        chk(s_mism == 1, "R8", "flag holds", s_mism, 1);
        set_dly(6, 7);
        flush();
        step(B_SNAP);
        k = stp;
        while (stp < k + 9) step('0);
        chk(int'(s_sbcnt) == exp_cnt(k + 8), "R10", "frozen counter", int'(s_sbcnt), exp_cnt(k + 8));
        chk(s_smism == 1, "R10", "frozen flag", s_smism, 1);
    endtask

    task automatic t_clear();
        clr = 1'b1;
        step('0);
        clr = 1'b0;
        step('0);
        chk(s_mism == 0, "R9", "flag after clear", s_mism, 0);
        repeat (8) step('0);
        chk(s_mism == 0, "R9", "flag stays clear", s_mism, 0);
    endtask

    initial begin
        t_reset();
        t_pulse(B_HDR, 2, 0, "R2");
        t_pulse(B_VETO, 3, 31, "R2");
        t_pulse(B_NZS, 5, 12, "R2");
        t_pulse(B_FERST, 1, 5, "R1");
        t_calib(4'hA, 9);
        t_calib(4'h5, 0);
        t_indep();
        t_reserved();
        t_presync();
        t_sync();
        t_wrap();
        t_ferst();
        t_mism();
        t_clear();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        #(8 * 200000);
        if (!finished) begin
            finished = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule